// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block manages a port of general-purpose pins. Software reaches it over a small register bus. One register holds the data to drive onto the port. One configuration register per pin chooses that pin's behaviour: whether its driver is enabled, open-drain operation, the pull-up, the input threshold type, the drive strength and the hand-over to an SPI peripheral. Two bits per pin that later interrupt logic will use are stored and read back only. For every pin the block produces a pad output value, a pad output enable, a pull-up enable, a threshold select and a sink-strength select. The pad input levels pass through a synchronizer and are returned when the data address is read.

Two pins carry a crystal oscillator. While the oscillator-enable input is high, their output drivers stay off whatever their configuration says. Four pins can be given to an SPI peripheral. While a pin's SPI-use bit is set, the peripheral's own output enable and data drive that pad. Threshold and sink strength are plain register bits sent to the pad. No analog behaviour is modelled here.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pad output enable is 0, every pull-up enable is 1, every threshold and sink select is 0, the data register is 0, and each configuration register reads 8'h02.
- R2: Address 0 selects the data register. Address 1+i selects the configuration of pin i. Its fields are: bit0 output enable, bit1 pull-up, bit2 open-drain, bit3 high sink, bit4 TTL threshold, bit5 interrupt active-low, bit6 interrupt enable, bit7 SPI use. A configuration read returns the last value written to it. Any other address reads 8'h00.
- R3: A read of address 0 returns the pad input levels after a two-flop synchronizer and never returns the stored data value. A change on the pads that is captured at clock edge A appears at the read port after edge A+1.
- R4: With open-drain clear and output enable set, pad_oe is 1 and pad_out follows the data bit.
- R5: With open-drain set and output enable set, pad_out is 0, and pad_oe is 1 only while the data bit is 0 (a data bit of 1 leaves the pin high-impedance).
- R6: With the output-enable bit clear, pad_oe is 0 for any data value and any open-drain setting.
- R7: While osc_en is 1, pad_oe of pins 0 and 1 is 0 even if their output-enable bits are set. When osc_en returns to 0, GPIO control is restored.
- R8: On pins 3 to 6, when SPI use is set, pad_oe equals spi_oe and pad_out equals spi_out of that pin, and the configured output-enable bit has no effect. Clearing SPI use returns the pin to GPIO control.
- R9: The SPI-use bit on pins outside 3 to 6, and the spi_oe and spi_out inputs of those pins, have no effect on the pads.
- R10: pad_pu, pad_ttl and pad_hisink equal the pull-up, TTL and high-sink configuration bits of each pin, in every mode.
- R11: osc_en has no effect on pins other than 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pull-up enables |
| pad_ttl | output | 8 | TTL threshold selects |
| pad_hisink | output | 8 | High sink-strength selects |
| osc_en | input | 1 | Oscillator enable; blocks the drivers of pins 0 and 1 |
| spi_oe | input | 8 | SPI peripheral output enables, per pin |
| spi_out | input | 8 | SPI peripheral output data, per pin |

## Verification
A configuration write and a change on the peripheral-side inputs (spi_oe, spi_out, osc_en) can land on the same clock edge. The bench provokes this by driving the write strobe and new SPI and oscillator inputs in the same cycle, for example setting SPI use on a pin while its SPI output enable toggles. A scoreboard holds the pad vectors expected from a requirement-level model. It compares them one cycle later, so the pad must show the peripheral values under the new configuration. A pad-input change and a read of the data address are also made to coincide, to judge the two-cycle synchronizer latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef struct packed {
      logic spi_use;
      logic irq_en;
      logic irq_low;
      logic ttl;
      logic hisink;
      logic od;
      logic pu;
      logic oe;
   } pin_cfg_t;

   localparam logic [7:0] CFG_RESET = 8'h02;
   localparam int         REG_W     = 8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      end else begin
         chain_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int ADDR_W   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic [REG_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]  pin_sync,
   output logic [NUM_PINS-1:0]  data_q,
   output pin_cfg_t             cfg_q [NUM_PINS]
);
   localparam logic [ADDR_W-1:0] DATA_ADDR = '0;

   if (NUM_PINS > REG_W) begin : g_bad_width
      $error("gpio_regs: NUM_PINS exceeds register width");
   end
   if ((2 ** ADDR_W) <= NUM_PINS) begin : g_bad_addr
      $error("gpio_regs: ADDR_W too small for the register map");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_q <= '0;
      else if (bus_wr && bus_addr == DATA_ADDR) data_q <= bus_wdata[NUM_PINS-1:0];
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cfg_q[i] <= pin_cfg_t'(CFG_RESET);
         else if (bus_wr && bus_addr == MY_ADDR) cfg_q[i] <= pin_cfg_t'(bus_wdata);
      end

      // R1: configuration registers come out of reset at the pull-up-only value
      a_r1_cfg_reset: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(rst_n) |-> cfg_q[i] == pin_cfg_t'(CFG_RESET));
      // R2: a write to address 1+i is held in that pin's configuration
      a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == MY_ADDR) |=> cfg_q[i] == pin_cfg_t'($past(bus_wdata)));
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == DATA_ADDR) begin
         bus_rdata[NUM_PINS-1:0] = pin_sync;
      end else begin
         for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_addr == ADDR_W'(i + 1)) bus_rdata = cfg_q[i];
         end
      end
   end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
   parameter bit SPI_CAPABLE = 1'b0,
   parameter bit OSC_PIN     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic data_bit,
   input  logic cfg_oe,
   input  logic cfg_pu,
   input  logic cfg_od,
   input  logic cfg_hisink,
   input  logic cfg_ttl,
   input  logic cfg_spi_use,
   input  logic osc_en,
   input  logic spi_oe,
   input  logic spi_out,
   output logic pad_out,
   output logic pad_oe,
   output logic pad_pu,
   output logic pad_ttl,
   output logic pad_hisink
);
   logic gpio_oe, gpio_out, osc_block, spi_sel;

   // GPIO path: open-drain turns the data bit into a tri-state control
   always_comb begin
      if (cfg_od) begin
         gpio_oe  = cfg_oe & ~data_bit;
         gpio_out = 1'b0;
      end else begin
         gpio_oe  = cfg_oe;
         gpio_out = data_bit;
      end
   end

   if (OSC_PIN) begin : g_osc
      assign osc_block = osc_en;
   end else begin : g_no_osc
      assign osc_block = 1'b0 & osc_en;
   end

   if (SPI_CAPABLE) begin : g_spi
      assign spi_sel = cfg_spi_use;
   end else begin : g_no_spi
      assign spi_sel = 1'b0 & cfg_spi_use;
   end

   assign pad_oe     = spi_sel ? spi_oe  : (gpio_oe & ~osc_block);
   assign pad_out    = spi_sel ? spi_out : gpio_out;
   assign pad_pu     = cfg_pu;
   assign pad_ttl    = cfg_ttl;
   assign pad_hisink = cfg_hisink;

   // R5: an open-drain GPIO pin never drives high
   a_r5_od_no_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_od && !spi_sel && pad_oe) |-> !pad_out);
   // R7: the oscillator blocks the driver on clock pins
   a_r7_osc_block: assert property (@(posedge clk) disable iff (!rst_n)
      (OSC_PIN && osc_en && !spi_sel) |-> !pad_oe);
   // R8: SPI ownership hands the pad to the peripheral
   a_r8_spi_owns: assert property (@(posedge clk) disable iff (!rst_n)
      (SPI_CAPABLE && cfg_spi_use) |-> (pad_oe == spi_oe && pad_out == spi_out));
   // R6: output-enable clear keeps a GPIO-owned driver off
   a_r6_oe_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_oe && !spi_sel) |-> !pad_oe);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int          NUM_PINS    = 8,
   parameter int          ADDR_W      = 4,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  OSC_MASK    = 8'b0000_0011,
   parameter logic [7:0]  SPI_MASK    = 8'b0111_1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] pad_ttl,
   output logic [NUM_PINS-1:0] pad_hisink,
   input  logic                osc_en,
   input  logic [NUM_PINS-1:0] spi_oe,
   input  logic [NUM_PINS-1:0] spi_out
);
   if ((OSC_MASK & SPI_MASK) != '0) begin : g_bad_masks
      $error("gpio_port_ctrl: oscillator and SPI pins must not overlap");
   end

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] data_q;
   pin_cfg_t            cfg_q [NUM_PINS];

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   gpio_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_sync  (pin_sync),
      .data_q    (data_q),
      .cfg_q     (cfg_q)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_pin_ctrl #(
         .SPI_CAPABLE (SPI_MASK[i]),
         .OSC_PIN     (OSC_MASK[i])
      ) u_pin (
         .clk         (clk),
         .rst_n       (rst_n),
         .data_bit    (data_q[i]),
         .cfg_oe      (cfg_q[i].oe),
         .cfg_pu      (cfg_q[i].pu),
         .cfg_od      (cfg_q[i].od),
         .cfg_hisink  (cfg_q[i].hisink),
         .cfg_ttl     (cfg_q[i].ttl),
         .cfg_spi_use (cfg_q[i].spi_use),
         .osc_en      (osc_en),
         .spi_oe      (spi_oe[i]),
         .spi_out     (spi_out[i]),
         .pad_out     (pad_out[i]),
         .pad_oe      (pad_oe[i]),
         .pad_pu      (pad_pu[i]),
         .pad_ttl     (pad_ttl[i]),
         .pad_hisink  (pad_hisink[i])
      );
   end
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
   localparam logic [7:0] OSC_M = 8'b0000_0011;
   localparam logic [7:0] SPI_M = 8'b0111_1000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_out, pad_oe, pad_pu, pad_ttl, pad_hisink;
   logic       osc_en = 1'b0;
   logic [7:0] spi_oe = '0;
   logic [7:0] spi_out = '0;

   always #5 clk = ~clk;

   gpio_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_ttl(pad_ttl),
      .pad_hisink(pad_hisink), .osc_en(osc_en), .spi_oe(spi_oe), .spi_out(spi_out)
   );

   typedef enum int {SEL_OE, SEL_OUT, SEL_PU, SEL_TTL, SEL_SINK, SEL_RD} sel_e;
   typedef struct {
      string      req;
      sel_e       sel;
      logic [7:0] exp;
   } item_t;

   item_t q[$];
   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;

   // requirement-level model state
   logic [7:0] m_cfg [8];
   logic [7:0] m_data;

   function automatic logic [7:0] model_oe();
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         if (SPI_M[i] && m_cfg[i][7])   r[i] = spi_oe[i];
         else if (OSC_M[i] && osc_en)   r[i] = 1'b0;
         else if (m_cfg[i][2])          r[i] = m_cfg[i][0] & ~m_data[i];
         else                           r[i] = m_cfg[i][0];
      end
      return r;
   endfunction

   function automatic logic [7:0] model_out();
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         if (SPI_M[i] && m_cfg[i][7]) r[i] = spi_out[i];
         else if (m_cfg[i][2])        r[i] = 1'b0;
         else                         r[i] = m_data[i];
      end
      return r;
   endfunction

   function automatic logic [7:0] field(int b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = m_cfg[i][b];
      return r;
   endfunction

   task automatic expect_item(string req, sel_e sel, logic [7:0] exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = exp;
      q.push_back(it);
   endtask

   task automatic expect_pads(string req);
      expect_item(req, SEL_OE, model_oe());
      expect_item(req, SEL_OUT, model_out());
      expect_item(req, SEL_PU, field(1));
      expect_item(req, SEL_TTL, field(4));
      expect_item(req, SEL_SINK, field(3));
   endtask

   task automatic do_write(logic [3:0] a, logic [7:0] d, string req);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 0) m_data = d;
      else if (a <= 8) m_cfg[a-1] = d;
      expect_pads(req);
   endtask

   task automatic set_side(logic o, logic [7:0] so, logic [7:0] sd, string req);
      @(negedge clk);
      osc_en = o; spi_oe = so; spi_out = sd;
      expect_pads(req);
   endtask

   task automatic check_read(logic [3:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      bus_addr = a;
      expect_item(req, SEL_RD, exp);
   endtask

   // monitor: compares queued expectations shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.sel)
               SEL_OE:   act = pad_oe;
               SEL_OUT:  act = pad_out;
               SEL_PU:   act = pad_pu;
               SEL_TTL:  act = pad_ttl;
               SEL_SINK: act = pad_hisink;
               default:  act = bus_rdata;
            endcase
            n_tests++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s %s: actual %h expected %h", it.req, it.sel.name(), act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_cfg[i] = 8'h02;
      m_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      expect_pads("R1");
      check_read(4'd1, 8'h02, "R1");
      check_read(4'd8, 8'h02, "R1");
      check_read(4'd0, 8'h00, "R1");
      // R2 register map: readback and unmapped addresses
      do_write(4'd6, 8'hE5, "R2");
      check_read(4'd6, 8'hE5, "R2");
      check_read(4'd9, 8'h00, "R2");
      check_read(4'd15, 8'h00, "R2");
      do_write(4'd6, 8'h02, "R2");
      // R4 push-pull on pin 2 and pin 7, two data patterns
      do_write(4'd3, 8'h01, "R4");
      do_write(4'd8, 8'h03, "R4");
      do_write(4'd0, 8'hA5, "R4");
      do_write(4'd0, 8'h5A, "R4");
      // R3 data read returns pins, not stored data (stored 5A, pins 00)
      check_read(4'd0, 8'h00, "R3");
      @(negedge clk);
      pad_in = 8'h3C; bus_addr = 4'd0;
      expect_item("R3", SEL_RD, 8'h00);
      @(negedge clk);
      expect_item("R3", SEL_RD, 8'h3C);
      // R5 open drain on pin 2 with data 1 then 0
      do_write(4'd3, 8'h05, "R5");
      do_write(4'd0, 8'h04, "R5");
      do_write(4'd0, 8'h00, "R5");
      // R6 open drain with output enable clear: never driven
      do_write(4'd3, 8'h04, "R6");
      do_write(4'd0, 8'hFF, "R6");
      // R10 pass-through bits
      do_write(4'd5, 8'h18, "R10");
      do_write(4'd2, 8'h0A, "R10");
      // R7 oscillator pins 0,1 output enabled then blocked
      do_write(4'd1, 8'h01, "R7");
      do_write(4'd2, 8'h03, "R7");
      set_side(1'b1, 8'h00, 8'h00, "R7");
      // R11 osc_en leaves other pins alone (pin 7 enabled)
      set_side(1'b1, 8'h00, 8'h00, "R11");
      set_side(1'b0, 8'h00, 8'h00, "R7");
      // R8 SPI pin 4: config oe set but SPI owns the pad
      do_write(4'd5, 8'h01, "R8");
      set_side(1'b0, 8'hFF, 8'h00, "R9");
      // same-cycle: SPI-use write lands with an SPI input change
      @(negedge clk);
      bus_addr = 4'd5; bus_wdata = 8'h80; bus_wr = 1'b1;
      spi_oe = 8'h00; spi_out = 8'hFF;
      @(negedge clk);
      bus_wr = 1'b0; m_cfg[4] = 8'h80;
      expect_pads("R8");
      set_side(1'b0, 8'h10, 8'h00, "R8");
      set_side(1'b1, 8'h10, 8'h10, "R8");
      do_write(4'd5, 8'h01, "R8");
      // R9 SPI-use bit on pin 7 and pin 0 has no effect
      do_write(4'd8, 8'h81, "R9");
      do_write(4'd1, 8'h81, "R9");
      set_side(1'b0, 8'h00, 8'h00, "R9");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule